// File: doc/BRIEF.md
# Extended Initiation Key Detector

This block watches the byte stream written to a card's configuration address port and decides when the host has sent the initiation key that unlocks configuration. The key is a run of 32 bytes produced by an 8-bit linear feedback shift register. When the board is strapped for its field-programming setup (legacy mode with all five option switches high), one extra fixed byte must follow before the key is accepted. After a complete match the block enters its configuration state and raises a programming enable for the on-chip memory. If entry came through the extended key, it also reports the fixed default read-data port address.

Writes arrive as a valid/ready byte stream. The block never applies back-pressure: `wr_ready` is held high, so a byte is consumed on every clock edge where `wr_valid` is high. Once the configuration state is reached, it is left only through bus reset.

Top module: `pnp_key_detector`

## Requirements
- R1: While `bus_rst` is high at a clock edge, the block returns to the waiting state (`key_state` = 2'b00) and clears its match progress. At the same edge `prog_en` and `rd_port_ovr` go low and `rd_port` goes to 0.
- R2: Outside the field-programming setup, 32 consecutive accepted writes equal to the key sequence move `key_state` to 2'b01 (configuration). This change is visible right after the edge that takes the 32nd byte. The key sequence starts at 0x6A. Each following byte is the previous one shifted right by one, with bit 0 XOR bit 1 placed into bit 7.
- R3: In the field-programming setup (`legacy_sel` = 1 and `cfg_sw` = 5'b11111), the 32 key bytes alone do not enter configuration. A 33rd write of 0x9C is required, and entry happens at that edge.
- R4: A write that differs from the expected byte discards the match progress. If that write is 0x6A, it is counted as the first key byte.
- R5: Any number of 0x00 writes, two or more, may come before a key without stopping the key that follows from being accepted.
- R6: `prog_en` is high exactly while `key_state` is 2'b01. In that state, further writes change no output until bus reset.
- R7: Entry through the extended key sets `rd_port_ovr` high and drives `rd_port` to 12'h203. Entry through the plain key leaves `rd_port_ovr` low and `rd_port` at 0.
- R8: `wr_ready` is always high. Clock edges where `wr_valid` is low do not advance or reset the match progress.
- R9: Legacy mode with any switch low uses the plain 32-byte key, with no trailing byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| bus_rst | input | 1 | Synchronous bus reset, active high |
| wr_valid | input | 1 | A byte is written to the address port this cycle |
| wr_ready | output | 1 | Always high, no back-pressure |
| wr_data | input | 8 | Byte written to the address port |
| legacy_sel | input | 1 | Legacy (non plug-and-play) mode selected |
| cfg_sw | input | 5 | Option switch inputs |
| key_state | output | 2 | 2'b00 waiting for key, 2'b01 configuration |
| prog_en | output | 1 | Memory programming enabled |
| rd_port_ovr | output | 1 | Default read-data port is in force |
| rd_port | output | 12 | Default read-data port address, or 0 |

## Verification
The assertions assume that `legacy_sel` and `cfg_sw` stay constant for the whole of a key sequence. They also assume that writes can come only through `wr_valid`, because there is no stall path. The stimulus changes the mode inputs only while `bus_rst` is high or before the first key byte. It drives bytes and gaps between posedge and negedge, and the reference model takes every mode and data value from the same pins the design sees.

// File: rtl/pnp_key_pkg.sv
package pnp_key_pkg;

  typedef enum logic [1:0] {
    KS_WAIT   = 2'b00,
    KS_CONFIG = 2'b01
  } key_state_e;

  // One step of the key generator: shift right, feedback of bit0^bit1 into bit 7
  function automatic logic [7:0] lfsr_step(input logic [7:0] cur);
    return {cur[0] ^ cur[1], cur[7:1]};
  endfunction

endpackage

// File: rtl/pnp_key_lfsr.sv
module pnp_key_lfsr
  import pnp_key_pkg::*;
#(
  parameter logic [7:0] SEED = 8'h6A
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       advance,
  input  logic       load_second,
  input  logic       load_seed,
  output logic [7:0] cur
);

  localparam logic [7:0] SECOND = lfsr_step(SEED);

  always_ff @(posedge clk) begin
    if (rst || load_seed) cur <= SEED;
    else if (load_second) cur <= SECOND;
    else if (advance)     cur <= lfsr_step(cur);
  end

  // R4: a restart on the seed byte leaves the generator one step past the seed
  a_r4_restart_second: assert property (@(posedge clk) disable iff (rst)
    (load_second && !load_seed) |=> (cur == SECOND));

endmodule

// File: rtl/pnp_key_count.sv
module pnp_key_count #(
  parameter int MAX   = 32,
  parameter int CNT_W = $clog2(MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             set_one,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (set_one) cnt <= CNT_W'(1);
    else if (inc)     cnt <= cnt + CNT_W'(1);
  end

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(MAX));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !(inc || set_one || clear) |=> $stable(cnt));

endmodule

// File: rtl/pnp_key_detector.sv
module pnp_key_detector
  import pnp_key_pkg::*;
#(
  parameter int          KEY_LEN  = 32,
  parameter logic [7:0]  SEED     = 8'h6A,
  parameter logic [7:0]  EXT_BYTE = 8'h9C,
  parameter int          SW_W     = 5,
  parameter int          PORT_W   = 12,
  parameter logic [11:0] DEF_PORT = 12'h203
) (
  input  logic              clk,
  input  logic              bus_rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  input  logic              legacy_sel,
  input  logic [SW_W-1:0]   cfg_sw,
  output logic [1:0]        key_state,
  output logic              prog_en,
  output logic              rd_port_ovr,
  output logic [PORT_W-1:0] rd_port
);

  localparam int CNT_W = $clog2(KEY_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_STD = CNT_W'(KEY_LEN - 1);
  localparam logic [CNT_W-1:0] EXT_IDX  = CNT_W'(KEY_LEN);

  key_state_e       state_q;
  logic             ovr_q;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       lfsr_cur;
  logic             sw_mode, take, at_ext, hit, final_hit, miss;
  logic             do_inc, do_one, do_clr;
  logic [7:0]       expect_byte;

  assign wr_ready = 1'b1;

  assign sw_mode   = legacy_sel && (&cfg_sw);
  assign take      = wr_valid && wr_ready && (state_q == KS_WAIT);
  assign at_ext    = sw_mode && (cnt == EXT_IDX);
  assign expect_byte = at_ext ? EXT_BYTE : lfsr_cur;
  assign hit       = take && (wr_data == expect_byte);
  assign final_hit = hit && (sw_mode ? (cnt == EXT_IDX) : (cnt >= LAST_STD));
  assign miss      = take && !hit;
  assign do_inc    = hit && !final_hit;
  assign do_one    = miss && (wr_data == SEED);
  assign do_clr    = final_hit || (miss && (wr_data != SEED));

  pnp_key_lfsr #(.SEED(SEED)) lfsr_i (
    .clk(clk), .rst(bus_rst), .advance(do_inc), .load_second(do_one),
    .load_seed(do_clr), .cur(lfsr_cur)
  );

  pnp_key_count #(.MAX(KEY_LEN), .CNT_W(CNT_W)) count_i (
    .clk(clk), .rst(bus_rst), .inc(do_inc), .set_one(do_one),
    .clear(do_clr), .cnt(cnt)
  );

  always_ff @(posedge clk) begin
    if (bus_rst) begin
      state_q <= KS_WAIT;
      ovr_q   <= 1'b0;
    end else if (final_hit) begin
      state_q <= KS_CONFIG;
      ovr_q   <= sw_mode;
    end
  end

  assign key_state   = state_q;
  assign prog_en     = (state_q == KS_CONFIG);
  assign rd_port_ovr = ovr_q;
  assign rd_port     = ovr_q ? PORT_W'(DEF_PORT) : '0;

  a_r6_config_holds: assert property (@(posedge clk) disable iff (bus_rst)
    (key_state == 2'b01) |=> (key_state == 2'b01));

  a_r2_entry_on_write: assert property (@(posedge clk) disable iff (bus_rst)
    $rose(prog_en) |-> $past(wr_valid));

  a_r7_ovr_in_config: assert property (@(posedge clk) disable iff (bus_rst)
    rd_port_ovr |-> prog_en);

  a_r3_ext_byte_last: assert property (@(posedge clk) disable iff (bus_rst)
    ($rose(prog_en) && $past(sw_mode)) |-> ($past(wr_data) == EXT_BYTE));

endmodule

// File: tb/pnp_key_detector_tb_top.sv
module pnp_key_detector_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        bus_rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        legacy_sel = 1'b0;
  logic [4:0]  cfg_sw = 5'b00000;
  logic        wr_ready, prog_en, rd_port_ovr;
  logic [1:0]  key_state;
  logic [11:0] rd_port;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  bit    started = 0, done = 0;
  string cur_tag = "R1";

  // reference model state
  int       m_cnt;
  bit [7:0] m_lfsr;
  bit       m_cfg, m_ovr;
  bit [7:0] key [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  pnp_key_detector dut_i (
    .clk(clk), .bus_rst(bus_rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .legacy_sel(legacy_sel), .cfg_sw(cfg_sw),
    .key_state(key_state), .prog_en(prog_en), .rd_port_ovr(rd_port_ovr),
    .rd_port(rd_port)
  );

  function automatic bit [7:0] nxt(input bit [7:0] v);
    return {v[0] ^ v[1], v[7:1]};
  endfunction

  always @(posedge clk) begin
    bit swm, last;
    bit [7:0] exp_b;
    cyc++;
    started = 1;
    if (bus_rst) begin
      m_cnt = 0; m_lfsr = 8'h6A; m_cfg = 0; m_ovr = 0;
    end else if (wr_valid && !m_cfg) begin
      swm   = legacy_sel && (cfg_sw == 5'b11111);
      exp_b = (swm && m_cnt == 32) ? 8'h9C : m_lfsr;
      if (wr_data == exp_b) begin
        last = swm ? (m_cnt == 32) : (m_cnt >= 31);
        if (last) begin
          m_cfg = 1; m_ovr = swm; m_cnt = 0; m_lfsr = 8'h6A;
        end else begin
          m_cnt++; m_lfsr = nxt(m_lfsr);
        end
      end else if (wr_data == 8'h6A) begin
        m_cnt = 1; m_lfsr = nxt(8'h6A);
      end else begin
        m_cnt = 0; m_lfsr = 8'h6A;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp_v, cyc);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !done) begin
      chk({cur_tag, " model key_state"}, key_state, m_cfg ? 2 'b01 : 2'b00);
      chk("R6 model prog_en", prog_en, m_cfg);
      chk("R7 model rd_port", rd_port, m_ovr ? 12'h203 : 12'h000);
      chk("R8 model wr_ready", wr_ready, 1);
    end
  end

  task automatic put(input bit [7:0] b);
    wr_valid = 1'b1; wr_data = b;
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset();
    bus_rst = 1'b1; idle(2); bus_rst = 1'b0;
  endtask

  task automatic send_key(input int from, input int upto);
    for (int i = from; i < upto; i++) put(key[i]);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    key[0] = 8'h6A;
    for (int i = 1; i < 32; i++) key[i] = nxt(key[i-1]);
    idle(1);
    do_reset();
    // R1 reset state
    cur_tag = "R1";
    chk("R1 state after reset", key_state, 0);
    chk("R1 prog_en after reset", prog_en, 0);
    chk("R1 rd_port after reset", rd_port, 0);

    // R2 + R5: preamble then plain key
    cur_tag = "R2";
    put(8'h00); put(8'h00); put(8'h00);
    send_key(0, 31);
    chk("R2 not yet after 31 bytes", key_state, 0);
    put(key[31]);
    chk("R2 config after 32nd byte", key_state, 1);
    chk("R5 preamble tolerated", prog_en, 1);
    chk("R7 plain entry no override", rd_port_ovr, 0);
    // R6 writes in config ignored
    cur_tag = "R6";
    put(8'h12); put(8'h6A); idle(2);
    chk("R6 config held after writes", key_state, 1);
    chk("R6 prog_en held", prog_en, 1);
    // R1 reset from config
    do_reset();
    chk("R1 reset leaves config", key_state, 0);

    // R3: extended key
    cur_tag = "R3";
    legacy_sel = 1'b1; cfg_sw = 5'b11111;
    send_key(0, 32);
    chk("R3 32 bytes insufficient", key_state, 0);
    put(8'h9C);
    chk("R3 config after 0x9C", key_state, 1);
    chk("R7 override set", rd_port_ovr, 1);
    chk("R7 default port 0x203", rd_port, 12'h203);

    // R3: wrong trailing byte
    do_reset();
    send_key(0, 32);
    put(8'h9D);
    put(8'h9C);
    chk("R3 wrong trailer rejected", key_state, 0);

    // R4: mismatch restarts, 0x6A counts as first
    cur_tag = "R4";
    do_reset();
    send_key(0, 10);
    put(8'h6A);
    send_key(1, 32);
    put(8'h9C);
    chk("R4 restart on seed byte", key_state, 1);
    do_reset();
    send_key(0, 20);
    put(8'h55);
    send_key(20, 32);
    put(8'h9C);
    chk("R4 mismatch discards progress", key_state, 0);

    // R9: legacy with one switch low -> plain key
    cur_tag = "R9";
    bus_rst = 1'b1; cfg_sw = 5'b11110; idle(2); bus_rst = 1'b0;
    send_key(0, 32);
    chk("R9 plain key in other legacy setup", key_state, 1);
    chk("R9 no override", rd_port_ovr, 0);

    // R8: gaps in valid do not disturb progress
    cur_tag = "R8";
    bus_rst = 1'b1; legacy_sel = 1'b0; cfg_sw = 5'b00000; idle(2); bus_rst = 1'b0;
    for (int i = 0; i < 32; i++) begin
      put(key[i]);
      if (i % 5 == 2) idle(3);
    end
    chk("R8 idle cycles hold progress", key_state, 1);
    chk("R8 ready high", wr_ready, 1);

    idle(3);
    finish_run();
  end

  initial begin
    wait (cyc > WATCHDOG);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
    finish_run();
  end

endmodule